// File: doc/BRIEF.md
# Scrambled Multi-Mode PWM Engine

This block turns sixteen 12-bit grayscale values into sixteen on/off drive signals for constant-current LED sinks. It does not send each value as one long pulse. It splits the 4096-period frame into equal segments and spreads each channel's on-time over them. The six high bits of a value set a base on-time in every segment. The six low bits add single extra periods to selected segments, so the sum over the frame equals the value exactly. A two-bit mode sets the segment count to 64, 16, 4 or 1. Fewer segments give fewer output transitions. More segments give a higher effective refresh rate.

The block runs on a fast reference clock `clk`. The slower grayscale clock `gclk_in` is synchronised into the `clk` domain, and each rising edge of it advances the frame position by one. A frame is loaded as one 192-bit word with a single-cycle `frame_load` strobe. The strobe is always accepted and has no back-pressure. New data is used either at once or at the next segment boundary, as `apply_now` selects. The channels are split into four groups that switch on successive reference-clock cycles, which spreads the supply current step. A watchdog darkens every output and rewinds the frame when `gclk_in` stops.

Top module: `scrambled_pwm_engine`

## Requirements
- R1: While reset is held and directly after it, every bit of `pwm_out` is 0.
- R2: With constant data, any 4096 consecutive GCLK periods hold exactly `v` on-periods on each channel. `v` is channel i's value at `frame_data[12*i+11:12*i]`. This holds in all four modes.
- R3: `gs_mode` 00, 01, 10 and 11 select 64, 16, 4 and 1 segments of 64, 256, 1024 and 4096 periods. On-time starts at the start of each segment, so a value of 2048 gives 64, 16, 4 and 1 pulses per frame.
- R4: Let p = 2*`gs_mode` and N = 64>>p. Segment k is on for (v[11:6]<<p) + (v[5:0]>>(6-p)) periods, plus one more period when k < (v[5:0] mod N).
- R5: With `apply_now`=1, loaded data takes effect from the next GCLK period, whatever the frame position.
- R6: With `apply_now`=0, loaded data is held back until the current segment's last period has been counted. Until then the outputs follow the old data.
- R7: Channel 4n+g is delayed by g reference-clock cycles relative to channel 4n, for g = 0..3.
- R8: When `stall_guard_en`=1 and no GCLK rising edge arrives for TIMEOUT_CYCLES reference cycles, all outputs go to 0.
- R9: When `stall_guard_en`=0 and GCLK stops, all outputs hold their last state.
- R10: After a stall blanking, counting restarts at frame position 0 on the first GCLK edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; sampling, stagger and stall timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| gclk_in | input | 1 | Grayscale clock, asynchronous to `clk` |
| gs_mode | input | 2 | Segmentation mode (00: 64 segments, 01: 16, 10: 4, 11: 1) |
| apply_now | input | 1 | 1: new data used at once; 0: held until a segment boundary |
| stall_guard_en | input | 1 | Enables blanking when GCLK stops |
| frame_load | input | 1 | Single-cycle strobe that captures `frame_data` |
| frame_data | input | 192 | Sixteen 12-bit values; channel i at bits 12*i+11..12*i |
| pwm_out | output | 16 | Staggered on/off drive, one bit per channel |

## Verification
The assertions assume that `gclk_in` stays high for at least one and low for at least one reference cycle. They also assume `frame_load` is a single-cycle pulse and that `gs_mode` does not change within a frame whose results are being judged. The stimulus toggles `gclk_in` on every reference cycle and loads data only between GCLK edges. It resets the block before each change of mode or sync setting. On-time is counted over whole frames, so the results do not depend on where a frame starts. Segment windows are offset by half a segment, so the few cycles of synchroniser and stagger latency do not affect the counts.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int GS_BITS        = 12;
  localparam int SEG_BITS       = 6;
  localparam int STAGGER_GROUPS = 4;

  typedef logic [GS_BITS:0] span_t;

  // log2 of the GCLK prescale inside one segment: 0, 2, 4, 6
  function automatic logic [3:0] prescale_log2(input logic [1:0] mode);
    return {1'b0, mode, 1'b0};
  endfunction

  // mask selecting the position within one segment
  function automatic logic [GS_BITS-1:0] segment_mask(input logic [1:0] mode);
    logic [3:0] sh;
    sh = 4'(SEG_BITS) + prescale_log2(mode);
    return GS_BITS'((span_t'(1) << sh) - span_t'(1));
  endfunction
endpackage

// File: rtl/spwm_gclk_monitor.sv
module spwm_gclk_monitor #(
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gclk_in,
  input  logic stall_guard_en,
  output logic tick,
  output logic stall_clr
);
  localparam int IW = $clog2(TIMEOUT_CYCLES + 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [IW-1:0]        idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], gclk_in};
  end

  assign tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           idle_q <= '0;
    else if (tick)                        idle_q <= '0;
    else if (idle_q != IW'(TIMEOUT_CYCLES)) idle_q <= idle_q + 1'b1;
  end

  assign stall_clr = stall_guard_en && !tick && (idle_q == IW'(TIMEOUT_CYCLES));

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);  // R2
endmodule

// File: rtl/spwm_frame_seq.sv
module spwm_frame_seq
  import spwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               stall_clr,
  input  logic [1:0]         gs_mode,
  output logic [GS_BITS-1:0] frame_pos,
  output logic               seg_last
);
  logic [GS_BITS-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frame_pos <= '0;
    else if (stall_clr) frame_pos <= '0;
    else if (tick)      frame_pos <= frame_pos + 1'b1;
  end

  assign mask     = segment_mask(gs_mode);
  assign seg_last = (frame_pos & mask) == mask;

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stall_clr && frame_pos == '1) |=> frame_pos == '0);  // R2
  AST_STALL_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    stall_clr |=> frame_pos == '0);  // R10
endmodule

// File: rtl/spwm_frame_store.sv
module spwm_frame_store
  import spwm_pkg::*;
#(
  parameter int CHANNELS = 16,
  localparam int W = CHANNELS * GS_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_load,
  input  logic         apply_now,
  input  logic [W-1:0] frame_data,
  input  logic         tick,
  input  logic         seg_last,
  output logic [W-1:0] active
);
  logic [W-1:0] pend_q;
  logic         pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else begin
      if (tick && seg_last && pend_v) begin
        active <= pend_q;
        pend_v <= 1'b0;
      end
      if (frame_load) begin
        if (apply_now) begin
          active <= frame_data;
        end else begin
          pend_q <= frame_data;
          pend_v <= 1'b1;
        end
      end
    end
  end

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(frame_load && apply_now) && !(tick && seg_last)) |=> $stable(active));  // R6
  AST_IMM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && apply_now) |=> active == $past(frame_data));  // R5
endmodule

// File: rtl/spwm_channel_cmp.sv
module spwm_channel_cmp
  import spwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               stall_clr,
  input  logic [1:0]         gs_mode,
  input  logic [GS_BITS-1:0] frame_pos,
  input  logic [GS_BITS-1:0] level,
  output logic               on_q
);
  localparam int HI_W = GS_BITS - SEG_BITS;

  logic [3:0]         sh_p, sh_n, sh_span;
  logic [GS_BITS-1:0] pos, seg_idx, lo_ext, base, rem;
  logic [HI_W-1:0]    hi;
  logic [SEG_BITS-1:0] lo;
  span_t              thr;
  logic               hit;

  always_comb begin
    sh_p    = prescale_log2(gs_mode);
    sh_n    = 4'(SEG_BITS) - sh_p;
    sh_span = 4'(SEG_BITS) + sh_p;
    hi      = level[GS_BITS-1:SEG_BITS];
    lo      = level[SEG_BITS-1:0];
    pos     = frame_pos & segment_mask(gs_mode);
    seg_idx = frame_pos >> sh_span;
    lo_ext  = GS_BITS'(lo);
    base    = lo_ext >> sh_n;
    rem     = lo_ext & ((GS_BITS'(1) << sh_n) - GS_BITS'(1));
    thr     = (span_t'(hi) << sh_p) + span_t'(base) + span_t'(seg_idx < rem);
    hit     = span_t'(pos) < thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         on_q <= 1'b0;
    else if (stall_clr) on_q <= 1'b0;
    else if (tick)      on_q <= hit;
  end

  AST_STALL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    stall_clr |=> !on_q);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stall_clr) |=> $stable(on_q));  // R9
endmodule

// File: rtl/spwm_stagger.sv
module spwm_stagger
  import spwm_pkg::*;
#(
  parameter int CHANNELS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] drive_in,
  output logic [CHANNELS-1:0] drive_out
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    localparam int D = i % STAGGER_GROUPS;
    if (D == 0) begin : g_direct
      assign drive_out[i] = drive_in[i];
    end else begin : g_delay
      logic [D:0] chain;
      assign chain[0] = drive_in[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[D:1] <= '0;
        else        chain[D:1] <= chain[D-1:0];
      end
      assign drive_out[i] = chain[D];

      AST_STAGGER_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> drive_out[i] == $past(drive_in[i], D));  // R7
    end
  end
endmodule

// File: rtl/scrambled_pwm_engine.sv
module scrambled_pwm_engine
  import spwm_pkg::*;
#(
  parameter int CHANNELS       = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 50_000_000,
  localparam int W = CHANNELS * GS_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gclk_in,
  input  logic [1:0]          gs_mode,
  input  logic                apply_now,
  input  logic                stall_guard_en,
  input  logic                frame_load,
  input  logic [W-1:0]        frame_data,
  output logic [CHANNELS-1:0] pwm_out
);
  logic               tick, stall_clr, seg_last;
  logic [GS_BITS-1:0] frame_pos;
  logic [W-1:0]       active;
  logic [CHANNELS-1:0] cmp_on;

  spwm_gclk_monitor #(
    .SYNC_STAGES   (SYNC_STAGES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .gclk_in(gclk_in),
    .stall_guard_en(stall_guard_en), .tick(tick), .stall_clr(stall_clr)
  );

  spwm_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stall_clr(stall_clr),
    .gs_mode(gs_mode), .frame_pos(frame_pos), .seg_last(seg_last)
  );

  spwm_frame_store #(.CHANNELS(CHANNELS)) u_store (
    .clk(clk), .rst_n(rst_n), .frame_load(frame_load), .apply_now(apply_now),
    .frame_data(frame_data), .tick(tick), .seg_last(seg_last), .active(active)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_cmp
    spwm_channel_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stall_clr(stall_clr),
      .gs_mode(gs_mode), .frame_pos(frame_pos),
      .level(active[c*GS_BITS +: GS_BITS]), .on_q(cmp_on[c])
    );
  end

  spwm_stagger #(.CHANNELS(CHANNELS)) u_stag (
    .clk(clk), .rst_n(rst_n), .drive_in(cmp_on), .drive_out(pwm_out)
  );

  AST_STALL_BLANK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_clr && $past(stall_clr) && $past(stall_clr, 2) && $past(stall_clr, 3))
      |=> pwm_out == '0);  // R8
endmodule

// File: tb/test_scrambled_pwm_engine.sv
module test_scrambled_pwm_engine;
  localparam int CH = 16;
  localparam int TO = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           gclk_in = 1'b0;
  logic [1:0]     gs_mode = 2'b00;
  logic           apply_now = 1'b1;
  logic           stall_guard_en = 1'b0;
  logic           frame_load = 1'b0;
  logic [CH*12-1:0] frame_data = '0;
  logic [CH-1:0]  pwm_out;

  always #2 clk = ~clk;

  scrambled_pwm_engine #(.CHANNELS(CH), .TIMEOUT_CYCLES(TO)) i_scrambled_pwm_engine (
    .clk(clk), .rst_n(rst_n), .gclk_in(gclk_in), .gs_mode(gs_mode),
    .apply_now(apply_now), .stall_guard_en(stall_guard_en),
    .frame_load(frame_load), .frame_data(frame_data), .pwm_out(pwm_out)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int vset [CH];

  bit arm = 1'b0;
  bit arm_ok = 1'b0;
  bit got [8];
  int rise [8];
  logic [7:0] prev_o = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (arm) begin
      if (!arm_ok && pwm_out[7:0] == 8'h00) arm_ok = 1'b1;
      else if (arm_ok)
        for (int c = 0; c < 8; c++)
          if (!got[c] && pwm_out[c] && !prev_o[c]) begin
            got[c] = 1'b1;
            rise[c] = cyc;
          end
    end
    prev_o = pwm_out[7:0];
  endtask

  task automatic gtick();
    gclk_in = 1'b1;
    step();
    gclk_in = 1'b0;
    step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) gtick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    gclk_in = 1'b0;
    frame_load = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic load_set();
    for (int c = 0; c < CH; c++) frame_data[c*12 +: 12] = 12'(vset[c]);
    frame_load = 1'b1;
    step();
    frame_load = 1'b0;
  endtask

  task automatic fill(input int v);
    for (int c = 0; c < CH; c++) vset[c] = v;
  endtask

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    int on_ct [CH];
    int rises;
    logic p0;
    int base_vals [CH] = '{2048, 0, 1, 63, 64, 65, 127, 4095,
                           4094, 4032, 1000, 3000, 17, 2049, 62, 2};

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) step();
    check(pwm_out == '0, "R1 during reset", int'(pwm_out), 0);
    do_reset();
    check(pwm_out == '0, "R1 after reset", int'(pwm_out), 0);

    // R2 / R3: whole-frame on-time and pulse count in every mode
    for (int m = 0; m < 4; m++) begin
      do_reset();
      gs_mode = 2'(m);
      apply_now = 1'b1;
      for (int c = 0; c < CH; c++) vset[c] = base_vals[c];
      load_set();
      ticks(40);
      for (int c = 0; c < CH; c++) on_ct[c] = 0;
      rises = 0;
      p0 = pwm_out[0];
      for (int t = 0; t < 4096; t++) begin
        gtick();
        for (int c = 0; c < CH; c++) on_ct[c] += int'(pwm_out[c]);
        if (pwm_out[0] && !p0) rises++;
        p0 = pwm_out[0];
      end
      for (int c = 0; c < CH; c++)
        check(on_ct[c] == base_vals[c], $sformatf("R2 mode %0d ch %0d", m, c),
              on_ct[c], base_vals[c]);
      check(rises == (64 >> (2 * m)), $sformatf("R3 mode %0d pulses", m),
            rises, 64 >> (2 * m));
    end

    // R4: per-segment on-time with spread low bits (modes 00 and 01)
    for (int m = 0; m < 2; m++) begin
      int v, p, nseg, span, hi, lo, cnt, k, exp;
      do_reset();
      gs_mode = 2'(m);
      apply_now = 1'b1;
      v = (m == 0) ? 100 : 300;
      fill(v);
      load_set();
      p = 2 * m;
      nseg = 64 >> p;
      span = 64 << p;
      hi = v >> 6;
      lo = v & 63;
      ticks(span / 2);
      for (int w = 0; w < nseg; w++) begin
        cnt = 0;
        for (int t = 0; t < span; t++) begin
          gtick();
          cnt += int'(pwm_out[0]);
        end
        k = (w + 1) % nseg;
        exp = (hi << p) + (lo >> (6 - p)) + ((k < (lo % nseg)) ? 1 : 0);
        check(cnt == exp, $sformatf("R4 mode %0d segment %0d", m, k), cnt, exp);
      end
    end

    // R5: immediate take-over mid-segment
    begin
      int cnt;
      do_reset();
      gs_mode = 2'b00;
      apply_now = 1'b1;
      ticks(10);
      fill(4095);
      load_set();
      ticks(5);
      cnt = 0;
      for (int t = 0; t < 40; t++) begin
        gtick();
        cnt += int'(pwm_out[3]);
      end
      check(cnt == 40, "R5 immediate data", cnt, 40);
    end

    // R6: deferred take-over waits for the segment end at position 63
    begin
      int cnt;
      do_reset();
      gs_mode = 2'b00;
      apply_now = 1'b0;
      ticks(10);
      fill(4095);
      load_set();
      cnt = 0;
      for (int t = 0; t < 40; t++) begin
        gtick();
        cnt += $countones(pwm_out);
      end
      check(cnt == 0, "R6 old data kept inside segment", cnt, 0);
      ticks(20);
      cnt = 0;
      for (int t = 0; t < 40; t++) begin
        gtick();
        cnt += int'(pwm_out[9]);
      end
      check(cnt == 40, "R6 new data after boundary", cnt, 40);
    end

    // R7: stagger between channels of one group
    begin
      do_reset();
      gs_mode = 2'b00;
      apply_now = 1'b1;
      fill(2048);
      load_set();
      for (int c = 0; c < 8; c++) got[c] = 1'b0;
      arm_ok = 1'b0;
      arm = 1'b1;
      ticks(200);
      arm = 1'b0;
      for (int g = 1; g < 4; g++)
        check(got[0] && got[g] && (rise[g] - rise[0] == g),
              $sformatf("R7 lag of group %0d", g), rise[g] - rise[0], g);
      for (int g = 0; g < 4; g++)
        check(got[4 + g] && rise[4 + g] == rise[g],
              $sformatf("R7 channel %0d matches channel %0d", 4 + g, g),
              rise[4 + g], rise[g]);
    end

    // R9, R8, R10: stopped GCLK with and without the guard
    begin
      int c0, c15;
      do_reset();
      gs_mode = 2'b11;
      apply_now = 1'b1;
      stall_guard_en = 1'b0;
      fill(4095);
      load_set();
      ticks(100);
      repeat (200) step();
      check(pwm_out == '1, "R9 outputs hold without guard", int'(pwm_out), 16'hFFFF);
      stall_guard_en = 1'b1;
      repeat (10) step();
      check(pwm_out == '0, "R8 outputs dark after stall", int'(pwm_out), 0);
      fill(100);
      load_set();
      c0 = 0;
      c15 = 0;
      for (int t = 0; t < 150; t++) begin
        gtick();
        c0 += int'(pwm_out[0]);
        c15 += int'(pwm_out[15]);
      end
      check(c0 == 100, "R10 restart from position 0 ch 0", c0, 100);
      check(c15 == 100, "R10 restart from position 0 ch 15", c15, 100);
    end

    summary();
  end
endmodule